// File: doc/BRIEF.md
# Banked General-Purpose Pin Controller

This block is a memory-mapped controller for sixteen general-purpose pins. The pins are grouped into four banks of unequal size: two, four, four and six pins. Each bank has a level register and a mode register. A single drive-style register chooses, pin by pin, whether an output pin pushes both levels or only pulls low.

Software writes a 4-bit mode nibble per pin to make the pin an input, a driven output, or leave it floating. It writes the level bits to set what an output pin presents. Reading the level register of an input pin returns the pad level after a two-stage synchronizer. Toward the pads, the block gives one output-enable and one output-value signal per pin, which the pad ring combines into a tri-state buffer.

The register port is a plain 32-bit bus. Writes are single-cycle, with a write strobe, an address and the write data. Read data is a combinational function of the address.

Top module: `pin_bank_ctrl`

## Requirements
- R1: After reset, every mode nibble holds 0x1 (input), every output level bit is 0, the drive-style register is 0 (push-pull), and every `pad_oe` bit is 0.
- R2: An input-mode pin reads, in bit (pin − first pin of its bank) of its bank's level register, the `pad_in` level captured by two clock edges. A change on the pad is not visible after one edge and is visible after the second.
- R3: A pin whose nibble is 0x8, with its drive-style bit at 0, has `pad_oe` = 1 and `pad_out` equal to its level bit. Reading its level register bit returns the written level.
- R4: A pin whose nibble is 0x8, with its drive-style bit at 1, drives low when its level bit is 0 (`pad_oe` = 1, `pad_out` = 0). It is released (`pad_oe` = 0) when its level bit is 1.
- R5: Nibble values other than 0x1 and 0x8 leave the pin undriven (`pad_oe` = 0) and read back exactly as written. A non-input pin's level bit reads back the written level.
- R6: In the level and mode registers, bits at or above a bank's used width (pin count, or 4 × pin count) read as zero and ignore writes.
- R7: The address map is as follows:
  - Level registers are at 0x170, 0x174, 0x178 and 0x17C, for pins 0–1, 2–5, 6–9 and 10–15.
  - Mode registers are at 0x180, 0x184, 0x188 and 0x18C.
  - A pin's nibble sits at bit 4 × (pin − first pin of its bank).
- R8: Writing a level bit while the pin is an input changes no pad signal. The stored level is driven once the pin is switched to mode 0x8.
- R9: The drive-style register at 0x190 holds bit p for pin p (1 = open-drain), with bits 31:16 reading as zero. Writes to unmapped addresses change nothing, and reads of them return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_addr | input | 12 | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` |
| pad_in | input | 16 | Sampled pad levels, asynchronous |
| pad_oe | output | 16 | Per-pin output enable toward the pad |
| pad_out | output | 16 | Per-pin output value toward the pad |

## Verification
The hardest case to reach from the ports is the synchronizer latency. A pad change has to be observed at exactly one edge, where it is still invisible, and then at the next edge, where it appears. The stimulus therefore keeps the read address fixed and changes `pad_in` at a falling edge. It then samples the level register after each of the next two rising edges. A second hard case is a level written while a pin is an input. That level is hidden at the pads until a later mode write exposes it, so the bench writes the level first, checks that the pads stay quiet, and only then switches the mode.

// File: rtl/pbc_pkg.sv
package pbc_pkg;
   localparam int unsigned N_BANKS = 4;
   localparam int unsigned BANK_PINS [N_BANKS] = '{2, 4, 4, 6};

   localparam int unsigned LEVEL_BASE = 'h170;
   localparam int unsigned MODE_BASE  = 'h180;
   localparam int unsigned STYLE_ADDR = 'h190;

   localparam int unsigned MODE_IN  = 'h1;
   localparam int unsigned MODE_OUT = 'h8;

   function automatic int unsigned pin_base(int unsigned bank);
      int unsigned acc;
      acc = 0;
      for (int unsigned k = 0; k < N_BANKS; k++)
         if (k < bank) acc += BANK_PINS[k];
      return acc;
   endfunction

   function automatic int unsigned total_pins();
      return pin_base(N_BANKS);
   endfunction
endpackage

// File: rtl/pbc_sync.sv
module pbc_sync #(
   parameter int unsigned WIDTH  = 16,
   parameter int unsigned STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);
   if (STAGES < 2) begin : g_bad_stages
      $error("pbc_sync needs at least two stages");
   end

   logic [WIDTH-1:0] stage_q [STAGES];
   logic [1:0]       warm_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int s = 0; s < STAGES; s++) stage_q[s] <= '0;
         warm_q <= '0;
      end else begin
         stage_q[0] <= d;
         for (int s = 1; s < STAGES; s++) stage_q[s] <= stage_q[s-1];
         if (warm_q != 2'd3) warm_q <= warm_q + 2'd1;
      end
   end

   assign q = stage_q[STAGES-1];

   // R2: each stage carries the previous stage's value by one edge
   p_first_stage_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (warm_q != 2'd0) |-> stage_q[0] == $past(d));
   for (genvar s = 1; s < STAGES; s++) begin : g_chain_chk
      p_chain_r2: assert property (@(posedge clk) disable iff (!rst_n)
         (warm_q != 2'd0) |-> stage_q[s] == $past(stage_q[s-1]));
   end
endmodule

// File: rtl/pbc_bank.sv
module pbc_bank
   import pbc_pkg::*;
#(
   parameter int unsigned NPINS  = 2,
   parameter int unsigned DATA_W = 32,
   parameter int unsigned MODE_W = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              level_we,
   input  logic              mode_we,
   input  logic [DATA_W-1:0] wdata,
   input  logic [NPINS-1:0]  pin_sync,
   output logic [DATA_W-1:0] level_rd,
   output logic [DATA_W-1:0] mode_rd,
   output logic [NPINS-1:0]  level_o,
   output logic [NPINS-1:0]  drive_o
);
   localparam int unsigned MODE_BITS = NPINS * MODE_W;
   localparam logic [MODE_W-1:0] CODE_IN  = MODE_W'(MODE_IN);
   localparam logic [MODE_W-1:0] CODE_OUT = MODE_W'(MODE_OUT);

   if (MODE_BITS > DATA_W || NPINS == 0) begin : g_bad_width
      $error("pbc_bank: mode field does not fit the data word");
   end

   logic [MODE_BITS-1:0] mode_q;
   logic [NPINS-1:0]     level_q;
   logic [NPINS-1:0]     rd_bits;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_q  <= {NPINS{CODE_IN}};
         level_q <= '0;
      end else begin
         if (mode_we)  mode_q  <= wdata[MODE_BITS-1:0];
         if (level_we) level_q <= wdata[NPINS-1:0];
      end
   end

   for (genvar i = 0; i < NPINS; i++) begin : g_pin
      logic [MODE_W-1:0] code;
      assign code       = mode_q[i*MODE_W +: MODE_W];
      assign drive_o[i] = (code == CODE_OUT);
      assign rd_bits[i] = (code == CODE_IN) ? pin_sync[i] : level_q[i];
   end

   assign level_o  = level_q;
   assign level_rd = DATA_W'(rd_bits);
   assign mode_rd  = DATA_W'(mode_q);

   // R5: mode field only moves on a mode write
   p_mode_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !mode_we |=> $stable(mode_q));
   // R8: stored level only moves on a level write, whatever the mode
   p_level_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !level_we |=> $stable(level_q));
endmodule

// File: rtl/pin_bank_ctrl.sv
module pin_bank_ctrl
   import pbc_pkg::*;
#(
   parameter int unsigned NUM_PINS    = 16,
   parameter int unsigned DATA_W      = 32,
   parameter int unsigned ADDR_W      = 12,
   parameter int unsigned MODE_W      = 4,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   input  logic [NUM_PINS-1:0] pad_in,
   output logic [NUM_PINS-1:0] pad_oe,
   output logic [NUM_PINS-1:0] pad_out
);
   localparam logic [ADDR_W-1:0] STYLE_A = ADDR_W'(STYLE_ADDR);

   if (NUM_PINS != total_pins() || NUM_PINS > DATA_W) begin : g_bad_pins
      $error("pin_bank_ctrl: pin count does not match the bank layout");
   end

   logic [NUM_PINS-1:0] sync_q;
   logic [NUM_PINS-1:0] level_all;
   logic [NUM_PINS-1:0] drive_all;
   logic [NUM_PINS-1:0] style_q;
   logic [DATA_W-1:0]   bank_level_rd [N_BANKS];
   logic [DATA_W-1:0]   bank_mode_rd  [N_BANKS];
   logic                style_we;

   pbc_sync #(.WIDTH(NUM_PINS), .STAGES(SYNC_STAGES)) i_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (pad_in),
      .q     (sync_q)
   );

   for (genvar b = 0; b < N_BANKS; b++) begin : g_bank
      localparam int unsigned BASE = pin_base(b);
      localparam int unsigned NP   = BANK_PINS[b];
      localparam logic [ADDR_W-1:0] LVL_A = ADDR_W'(LEVEL_BASE + 4*b);
      localparam logic [ADDR_W-1:0] MOD_A = ADDR_W'(MODE_BASE + 4*b);

      pbc_bank #(.NPINS(NP), .DATA_W(DATA_W), .MODE_W(MODE_W)) i_bank (
         .clk      (clk),
         .rst_n    (rst_n),
         .level_we (bus_wr && bus_addr == LVL_A),
         .mode_we  (bus_wr && bus_addr == MOD_A),
         .wdata    (bus_wdata),
         .pin_sync (sync_q[BASE +: NP]),
         .level_rd (bank_level_rd[b]),
         .mode_rd  (bank_mode_rd[b]),
         .level_o  (level_all[BASE +: NP]),
         .drive_o  (drive_all[BASE +: NP])
      );
   end

   assign style_we = bus_wr && bus_addr == STYLE_A;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        style_q <= '0;
      else if (style_we) style_q <= bus_wdata[NUM_PINS-1:0];
   end

   always_comb begin
      bus_rdata = '0;
      for (int b = 0; b < N_BANKS; b++) begin
         if (bus_addr == ADDR_W'(LEVEL_BASE + 4*b)) bus_rdata = bank_level_rd[b];
         if (bus_addr == ADDR_W'(MODE_BASE + 4*b))  bus_rdata = bank_mode_rd[b];
      end
      if (bus_addr == STYLE_A) bus_rdata = DATA_W'(style_q);
   end

   for (genvar p = 0; p < NUM_PINS; p++) begin : g_pad
      assign pad_oe[p]  = drive_all[p] & (style_q[p] ? ~level_all[p] : 1'b1);
      assign pad_out[p] = drive_all[p] & ~style_q[p] & level_all[p];

      // R4: an open-drain pin at level 1 is released
      p_od_release_r4: assert property (@(posedge clk) disable iff (!rst_n)
         (style_q[p] && level_all[p]) |-> !pad_oe[p]);
      // R3: a pin presenting a high value is always enabled
      p_high_enabled_r3: assert property (@(posedge clk) disable iff (!rst_n)
         pad_out[p] |-> pad_oe[p]);
   end

   // R9: drive-style bits only change on a write to their address
   p_style_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !style_we |=> $stable(style_q));
endmodule

// File: tb/test_pin_bank_ctrl.sv
`timescale 1ns/1ps
module test_pin_bank_ctrl;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_wr = 1'b0;
   logic [11:0] bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic [15:0] pad_in = '0;
   logic [15:0] pad_oe;
   logic [15:0] pad_out;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   pin_bank_ctrl i_pin_bank_ctrl (
      .clk       (clk),
      .rst_n     (rst_n),
      .bus_wr    (bus_wr),
      .bus_addr  (bus_addr),
      .bus_wdata (bus_wdata),
      .bus_rdata (bus_rdata),
      .pad_in    (pad_in),
      .pad_oe    (pad_oe),
      .pad_out   (pad_out)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [11:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic rd_chk(input string req, input logic [11:0] a, input logic [31:0] exp);
      bus_addr = a;
      #1;
      chk(req, bus_rdata, exp);
   endtask

   task automatic t_reset;
      rd_chk("R1 mode bank0", 12'h180, 32'h11);
      rd_chk("R1 mode bank1", 12'h184, 32'h1111);
      rd_chk("R1 mode bank2", 12'h188, 32'h1111);
      rd_chk("R1 mode bank3", 12'h18C, 32'h111111);
      rd_chk("R1 style", 12'h190, 32'h0);
      chk("R1 pad_oe", {16'h0, pad_oe}, 32'h0);
   endtask

   task automatic t_push_pull;
      wr(12'h18C, 32'h888888);
      wr(12'h17C, 32'h2A);
      #1;
      chk("R3 oe bank3", {26'h0, pad_oe[15:10]}, 32'h3F);
      chk("R3 out bank3", {26'h0, pad_out[15:10]}, 32'h2A);
      chk("R7 other pins idle", {16'h0, pad_oe[9:0]}, 32'h0);
      rd_chk("R3 level readback", 12'h17C, 32'h2A);
   endtask

   task automatic t_high_bits;
      wr(12'h180, 32'hFFFF_FF88);
      wr(12'h170, 32'hFFFF_FFFF);
      rd_chk("R6 mode bank0 upper", 12'h180, 32'h88);
      rd_chk("R6 level bank0 upper", 12'h170, 32'h3);
      chk("R6 bank1 untouched", {16'h0, pad_oe}, 32'hFC03);
   endtask

   task automatic t_open_drain;
      wr(12'h190, 32'hFFFF_0001);
      rd_chk("R9 style upper zero", 12'h190, 32'h1);
      chk("R4 released oe", {30'h0, pad_oe[1:0]}, 32'h2);
      chk("R4 released out", {30'h0, pad_out[1:0]}, 32'h2);
      wr(12'h170, 32'h2);
      #1;
      chk("R4 pull low oe", {30'h0, pad_oe[1:0]}, 32'h3);
      chk("R4 pull low out", {30'h0, pad_out[1:0]}, 32'h2);
   endtask

   task automatic t_other_modes;
      wr(12'h184, 32'h0000_F0A3);
      wr(12'h174, 32'hF);
      rd_chk("R5 mode readback", 12'h184, 32'hF0A3);
      rd_chk("R5 level readback", 12'h174, 32'hF);
      chk("R5 undriven", {28'h0, pad_oe[5:2]}, 32'h0);
   endtask

   task automatic t_sync;
      @(negedge clk);
      bus_addr = 12'h178;
      pad_in[9:6] = 4'hB;
      #1 chk("R2 before edge", bus_rdata, 32'h0);
      @(negedge clk);
      #1 chk("R2 after one edge", bus_rdata, 32'h0);
      @(negedge clk);
      #1 chk("R2 after two edges", bus_rdata, 32'hB);
   endtask

   task automatic t_latch_hold;
      wr(12'h178, 32'h5);
      rd_chk("R8 input still reads pad", 12'h178, 32'hB);
      chk("R8 pads quiet", {28'h0, pad_oe[9:6]}, 32'h0);
      wr(12'h188, 32'h8888);
      #1;
      chk("R8 oe after switch", {28'h0, pad_oe[9:6]}, 32'hF);
      chk("R8 out after switch", {28'h0, pad_out[9:6]}, 32'h5);
      rd_chk("R8 level readback", 12'h178, 32'h5);
   endtask

   task automatic t_unmapped;
      wr(12'h194, 32'hFFFF_FFFF);
      wr(12'h16C, 32'hFFFF_FFFF);
      rd_chk("R9 unmapped reads zero", 12'h194, 32'h0);
      rd_chk("R9 style unchanged", 12'h190, 32'h1);
      rd_chk("R9 bank3 unchanged", 12'h17C, 32'h2A);
      rd_chk("R9 bank3 mode unchanged", 12'h18C, 32'h888888);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      #1 t_reset();
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      t_push_pull();
      t_high_bits();
      t_open_drain();
      t_other_modes();
      t_sync();
      t_latch_hold();
      t_unmapped();
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual hung expected done");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end
endmodule